// File: doc/BRIEF.md
# Push-pull two-wire serial engine

This block is the bit-level master of a two-wire serial bus that connects to exactly one target. Since only one target exists, a frame carries no device address. It opens with a start condition and sends an 8-bit register address. It then writes, or reads back, between one and eight data bytes, and it closes with a stop condition. Every byte on the wire is followed by an even-parity bit. No acknowledge slot is ever inserted. A read is a single frame: the address goes out, the engine releases the data line, and the target returns its bytes.

The engine drives the clock line push-pull. Each clock phase lasts a programmable number of parent-clock cycles. The data line may change a programmable number of cycles after the clock falls. Each line can be forced by an override, and both lines are synchronised back as sense outputs. All transfer settings are captured when a start pulse is accepted. An abort returns the engine to idle at once.

Top module: `ppw_master`

## Requirements
- R1: After reset and while idle with no override, scl_o=1, sda_o=1, sda_oe=1, busy=0, done=0, err=0.
- R2: A frame is: a start condition (data line falls while scl_o is high), then the register address MSB first and its parity bit, then the data bytes, then a stop condition (data line rises while scl_o is high). There is no device address and no acknowledge bit. The number of clock rising edges is 9*(bytes+1)+1, where the last edge belongs to the stop.
- R3: The parity bit after each byte, in both directions, equals the XOR of that byte's 8 bits (even parity).
- R4: On a write (rd_nwr=0), len_m1+1 bytes are sent. Data byte k is taken from wdata[8k+7:8k] and is sent MSB first.
- R5: On a read (rd_nwr=1), the address byte and its parity are driven. After that, sda_oe=0 during each data bit and parity bit. The line is sampled in the last cycle of each clock-high phase. Received byte k lands in rdata[8k+7:8k], and unused bytes read as zero.
- R6: On a read, if a received parity bit differs from the XOR of its byte, err=1 and err_idx holds the 1-based index of the first such byte. Both are valid from done until the next accepted start. A clean read leaves err=0 and err_idx=0.
- R7: Each clock-low and clock-high phase lasts H = max(clk_div,1) clk cycles, so successive clock rising edges are 2H cycles apart. clk_div=0 behaves as 1.
- R8: A driven data-line change happens exactly sda_dly cycles after the clock falling edge, given sda_dly < H. The driven data value is stable for the whole clock-high phase of every bit.
- R9: done is a single-cycle pulse issued when the stop condition completes. busy is 1 from the cycle after an accepted start until the cycle done is issued.
- R10: A start pulse while busy is ignored. The frame keeps the settings that were captured at the accepted start, and only one done results.
- R11: An abort while busy makes busy=0, scl_o=1, sda_o=1 and sda_oe=1 on the next cycle. No done is issued for that frame.
- R12: scl_ovr_en forces scl_o to scl_ovr_val. sda_ovr_en forces sda_o to sda_ovr_val with sda_oe=1. Each override is independent of the other.
- R13: scl_state and sda_state follow scl_in and sda_in through a two-stage synchroniser, so they reflect the lines two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: begin a frame when idle |
| abort | input | 1 | Pulse: drop the current frame |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| len_m1 | input | 3 | Data byte count minus one |
| reg_addr | input | 8 | Register address byte |
| wdata | input | 64 | Write bytes, byte k at [8k+7:8k] |
| clk_div | input | 8 | Clock phase length in clk cycles (0 acts as 1) |
| sda_dly | input | 3 | Data change delay after the clock falls |
| scl_ovr_en | input | 1 | Force the clock line |
| scl_ovr_val | input | 1 | Forced clock value |
| sda_ovr_en | input | 1 | Force the data line |
| sda_ovr_val | input | 1 | Forced data value |
| scl_in | input | 1 | Clock line sense |
| sda_in | input | 1 | Data line sense |
| scl_o | output | 1 | Clock line drive |
| sda_o | output | 1 | Data line drive value |
| sda_oe | output | 1 | Data line drive enable |
| scl_state | output | 1 | Synchronised clock line state |
| sda_state | output | 1 | Synchronised data line state |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |
| err | output | 1 | Read parity error seen |
| err_idx | output | 4 | 1-based index of the first bad byte |
| rdata | output | 64 | Read bytes, byte k at [8k+7:8k] |

## Verification
The bench acts as the target. It records the data line at every clock rising edge, and on reads it drives bytes whose parity bits can be deliberately corrupted. This exposes an engine that inserts an acknowledge slot or a device address, sends bytes LSB first, uses odd parity, or reports the last bad byte or a 0-based index instead of the first. Corner cases include the shortest phase (clk_div=0) with no delay, the longest phase with the largest delay, and a full eight-byte read whose last byte is bad. A wrong divider floor or an off-by-one delay shows up as a wrong edge spacing or a wrong SDA lag. A second start pulse in mid-frame and an abort in mid-frame are also applied. These catch an engine that relatches its settings, issues a done on abort, or leaves the lines driven low.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
    localparam int BYTE_W    = 8;
    localparam int DIV_W     = 8;
    localparam int DLY_W     = 3;
    localparam int LEN_W     = 3;
    localparam int MAX_BYTES = 1 << LEN_W;
    localparam int DATA_W    = MAX_BYTES * BYTE_W;
    localparam int IDX_W     = $clog2(MAX_BYTES + 1);
    localparam int BIT_W     = $clog2(BYTE_W + 1);
    localparam int PAR_POS   = BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI
    } phase_e;

    typedef struct packed {
        logic oe;
        logic val;
    } sda_drv_t;

    typedef struct packed {
        logic                 rd;
        logic [LEN_W-1:0]     len_m1;
        logic [BYTE_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic [DIV_W-1:0]     div;
        logic [DLY_W-1:0]     dly;
    } xfer_cfg_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] b);
        return ^b;
    endfunction

    function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction
endpackage

// File: rtl/ppw_halfper.sv
module ppw_halfper
    import ppw_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] reload;

    always_comb begin
        reload = ((div == '0) ? DW'(1) : div) - DW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - DW'(1);
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/ppw_sda_delay.sv
module ppw_sda_delay
    import ppw_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  sda_drv_t      din,
    input  logic [DW-1:0] sel,
    output sda_drv_t      dout
);
    localparam int DEPTH = (1 << DW) - 1;
    localparam sda_drv_t IDLE_DRV = '{oe: 1'b1, val: 1'b1};

    sda_drv_t tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= IDLE_DRV;
        end else begin
            tap[0] <= din;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    always_comb begin
        if (sel == '0) dout = din;
        else           dout = tap[sel - DW'(1)];
    end
endmodule

// File: rtl/ppw_sense_sync.sv
module ppw_sense_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ppw_master.sv
module ppw_master
    import ppw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              rd_nwr,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DLY_W-1:0]  sda_dly,
    input  logic              scl_ovr_en,
    input  logic              scl_ovr_val,
    input  logic              sda_ovr_en,
    input  logic              sda_ovr_val,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_oe,
    output logic              scl_state,
    output logic              sda_state,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [IDX_W-1:0]  err_idx,
    output logic [DATA_W-1:0] rdata
);
    localparam int BSEL_W = LEN_W + $clog2(BYTE_W);

    phase_e            st;
    xfer_cfg_t         cfg;
    logic [IDX_W-1:0]  byte_idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx_sh;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic [IDX_W-1:0]  err_idx_q;
    logic              done_q;

    logic              tick;
    logic [DIV_W-1:0]  div_sel;
    logic [DLY_W-1:0]  dly_q;
    logic [DIV_W-1:0]  div_q;
    logic              rd_q;
    logic [LEN_W-1:0]  data_sel;
    logic [BSEL_W-1:0] data_base;
    logic [BYTE_W-1:0] cur_byte;
    logic              tx_bit;
    logic              driving;
    logic              last_byte;
    logic              flush;
    logic              eng_scl;
    sda_drv_t          eng_drv;
    sda_drv_t          drv_out;

    assign dly_q = cfg.dly;
    assign div_q = cfg.div;
    assign rd_q  = cfg.rd;

    // Phase timer: while idle it preloads from the live divider so the
    // first phase after a start already has the captured length.
    assign div_sel = (st == ST_IDLE) ? clk_div : cfg.div;

    ppw_halfper #(.DW(DIV_W)) u_halfper (
        .clk  (clk),
        .rst  (rst),
        .run  (st != ST_IDLE),
        .div  (div_sel),
        .tick (tick)
    );

    // Byte and bit selection
    assign data_sel  = LEN_W'(byte_idx - IDX_W'(1));
    assign data_base = {data_sel, {$clog2(BYTE_W){1'b0}}};
    assign cur_byte  = (byte_idx == '0) ? cfg.addr : cfg.wdata[data_base +: BYTE_W];
    assign tx_bit    = (bit_idx == BIT_W'(PAR_POS)) ? even_par(cur_byte)
                                                    : cur_byte[3'd7 - bit_idx[2:0]];
    assign driving   = (byte_idx == '0) || !cfg.rd;
    assign last_byte = (byte_idx == (IDX_W'(cfg.len_m1) + IDX_W'(1)));
    assign flush     = abort && (st != ST_IDLE);

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cfg       <= '0;
            byte_idx  <= '0;
            bit_idx   <= '0;
            rx_sh     <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
            err_idx_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (flush) begin
                st <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (start) begin
                            cfg.rd     <= rd_nwr;
                            cfg.len_m1 <= len_m1;
                            cfg.addr   <= reg_addr;
                            cfg.wdata  <= wdata;
                            cfg.div    <= clk_div;
                            cfg.dly    <= sda_dly;
                            byte_idx   <= '0;
                            bit_idx    <= '0;
                            rx_sh      <= '0;
                            rdata_q    <= '0;
                            err_q      <= 1'b0;
                            err_idx_q  <= '0;
                            st         <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (tick) st <= ST_BIT_LO;
                    end
                    ST_BIT_LO: begin
                        if (tick) st <= ST_BIT_HI;
                    end
                    ST_BIT_HI: begin
                        if (tick) begin
                            if (!driving) begin
                                if (bit_idx != BIT_W'(PAR_POS)) begin
                                    rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                                end else begin
                                    rdata_q[data_base +: BYTE_W] <= rx_sh;
                                    if ((even_par(rx_sh) != sda_in) && !err_q) begin
                                        err_q     <= 1'b1;
                                        err_idx_q <= byte_idx;
                                    end
                                end
                            end
                            if (bit_idx == BIT_W'(PAR_POS)) begin
                                bit_idx <= '0;
                                if (last_byte) begin
                                    st <= ST_STOP_LO;
                                end else begin
                                    byte_idx <= byte_idx + IDX_W'(1);
                                    st       <= ST_BIT_LO;
                                end
                            end else begin
                                bit_idx <= bit_idx + BIT_W'(1);
                                st      <= ST_BIT_LO;
                            end
                        end
                    end
                    ST_STOP_LO: begin
                        if (tick) st <= ST_STOP_HI;
                    end
                    ST_STOP_HI: begin
                        if (tick) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Line levels per phase
    always_comb begin
        eng_scl = 1'b1;
        eng_drv = '{oe: 1'b1, val: 1'b1};
        case (st)
            ST_IDLE:    begin eng_scl = 1'b1; eng_drv = '{oe: 1'b1, val: 1'b1}; end
            ST_START:   begin eng_scl = 1'b1; eng_drv = '{oe: 1'b1, val: 1'b0}; end
            ST_BIT_LO:  begin eng_scl = 1'b0; eng_drv = '{oe: driving, val: driving ? tx_bit : 1'b1}; end
            ST_BIT_HI:  begin eng_scl = 1'b1; eng_drv = '{oe: driving, val: driving ? tx_bit : 1'b1}; end
            ST_STOP_LO: begin eng_scl = 1'b0; eng_drv = '{oe: 1'b1, val: 1'b0}; end
            ST_STOP_HI: begin eng_scl = 1'b1; eng_drv = '{oe: 1'b1, val: 1'b0}; end
            default:    begin eng_scl = 1'b1; eng_drv = '{oe: 1'b1, val: 1'b1}; end
        endcase
    end

    ppw_sda_delay #(.DW(DLY_W)) u_sda_delay (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .din   (eng_drv),
        .sel   (cfg.dly),
        .dout  (drv_out)
    );

    ppw_sense_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sense (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   ({scl_state, sda_state})
    );

    // Override muxes
    assign scl_o  = scl_ovr_en ? scl_ovr_val : eng_scl;
    assign sda_o  = sda_ovr_en ? sda_ovr_val : drv_out.val;
    assign sda_oe = sda_ovr_en | drv_out.oe;

    assign busy    = (st != ST_IDLE);
    assign done    = done_q;
    assign err     = err_q;
    assign err_idx = err_idx_q;
    assign rdata   = rdata_q;
endmodule

// File: rtl/ppw_master_chk.sv
module ppw_master_chk
    import ppw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input phase_e           st,
    input logic             abort,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [IDX_W-1:0] err_idx,
    input logic             scl_o,
    input logic             scl_ovr_en,
    input sda_drv_t         drv_out,
    input logic             rd_q,
    input logic [IDX_W-1:0] byte_idx,
    input logic [DLY_W-1:0] dly_q,
    input logic [DIV_W-1:0] div_q
);
    logic dly_ok;
    assign dly_ok = (DIV_W'(dly_q) < half_len(div_q));

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (abort && busy) |=> (!busy && !done)); // R11

    AST_IDLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!busy && !scl_ovr_en) |-> scl_o); // R1

    AST_ERR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_idx != '0 && err_idx <= IDX_W'(MAX_BYTES))); // R6

    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT_HI && $past(st) == ST_BIT_HI && dly_ok) |-> $stable(drv_out)); // R8

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT_HI && $past(st) == ST_BIT_HI && rd_q && byte_idx != '0 && dly_ok)
            |-> !drv_out.oe); // R5
endmodule

bind ppw_master ppw_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .abort      (abort),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .err_idx    (err_idx),
    .scl_o      (scl_o),
    .scl_ovr_en (scl_ovr_en),
    .drv_out    (drv_out),
    .rd_q       (rd_q),
    .byte_idx   (byte_idx),
    .dly_q      (dly_q),
    .div_q      (div_q)
);

// File: tb/tb_ppw_master.sv
module tb_ppw_master;
    import ppw_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              start = 0, abort = 0, rd_nwr = 0;
    logic [LEN_W-1:0]  len_m1 = '0;
    logic [BYTE_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DIV_W-1:0]  clk_div = 8'd2;
    logic [DLY_W-1:0]  sda_dly = '0;
    logic scl_ovr_en = 0, scl_ovr_val = 0, sda_ovr_en = 0, sda_ovr_val = 0;
    logic scl_in, sda_in;
    logic scl_o, sda_o, sda_oe, scl_state, sda_state, busy, done, err;
    logic [IDX_W-1:0]  err_idx;
    logic [DATA_W-1:0] rdata;
    logic tgt_sda = 1'b1;

    assign sda_in = sda_oe ? sda_o : tgt_sda;
    assign scl_in = scl_o;

    ppw_master dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .rd_nwr(rd_nwr),
        .len_m1(len_m1), .reg_addr(reg_addr), .wdata(wdata), .clk_div(clk_div),
        .sda_dly(sda_dly), .scl_ovr_en(scl_ovr_en), .scl_ovr_val(scl_ovr_val),
        .sda_ovr_en(sda_ovr_en), .sda_ovr_val(sda_ovr_val), .scl_in(scl_in),
        .sda_in(sda_in), .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe),
        .scl_state(scl_state), .sda_state(sda_state), .busy(busy), .done(done),
        .err(err), .err_idx(err_idx), .rdata(rdata)
    );

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus monitor and target model state
    logic [DATA_W-1:0] cur_wd;
    logic [BYTE_W-1:0] cur_addr;
    logic              cur_rd;
    int                cur_n;
    logic [7:0]        tgt_bad;
    int  exp_h, exp_d;
    logic bits [100];
    int  nrise, nstart, nstop, ndone, since_rise, since_fall;
    bit  per_bad, dly_bad;
    logic prev_scl = 1, prev_sda = 1, prev_oe = 1;

    task automatic mon_clear();
        nrise = 0; nstart = 0; nstop = 0; ndone = 0;
        since_rise = 0; since_fall = 0; per_bad = 0; dly_bad = 0;
    endtask

    always @(negedge clk) begin
        since_rise = since_rise + 1;
        since_fall = since_fall + 1;
        if (scl_o && !prev_scl) begin
            if (nrise > 0 && since_rise != 2 * exp_h) per_bad = 1;
            since_rise = 0;
            if (nrise < 100) bits[nrise] = sda_in;
            nrise = nrise + 1;
        end
        if (!scl_o && prev_scl) begin
            since_fall = 0;
            // target presents the bit that follows nrise rising edges
            if (cur_rd && nrise >= 9 && ((nrise - 9) / 9) < cur_n) begin
                automatic int j = (nrise - 9) / 9;
                automatic int b = (nrise - 9) % 9;
                automatic logic [7:0] tb_byte = cur_wd[j*8 +: 8];
                tgt_sda = (b < 8) ? tb_byte[7-b] : ((^tb_byte) ^ tgt_bad[j]);
            end else begin
                tgt_sda = 1'b1;
            end
        end
        if (prev_scl && scl_o && prev_sda && !sda_in) nstart = nstart + 1;
        if (prev_scl && scl_o && !prev_sda && sda_in) nstop = nstop + 1;
        if (!scl_o && prev_oe && sda_oe && !sda_ovr_en && (sda_in != prev_sda)
            && since_fall != exp_d) dly_bad = 1;
        if (done) ndone = ndone + 1;
        prev_scl = scl_o;
        prev_sda = sda_in;
        prev_oe  = sda_oe;
    end

    function automatic logic exp_bit(input int i);
        automatic int j = i / 9;
        automatic int b = i % 9;
        automatic logic [7:0] byt = (j == 0) ? cur_addr : cur_wd[(j-1)*8 +: 8];
        automatic logic flip = (cur_rd && j > 0) ? tgt_bad[j-1] : 1'b0;
        return (b < 8) ? byt[7-b] : ((^byt) ^ flip);
    endfunction

    function automatic logic [DATA_W-1:0] exp_rdata();
        logic [DATA_W-1:0] r = '0;
        for (int k = 0; k < cur_n; k++) r[k*8 +: 8] = cur_wd[k*8 +: 8];
        return r;
    endfunction

    function automatic int exp_eidx();
        for (int k = 0; k < cur_n; k++) if (tgt_bad[k]) return k + 1;
        return 0;
    endfunction

    task automatic run_txn(input logic rd, input logic [2:0] lm1, input logic [7:0] ad,
                           input logic [63:0] wd, input logic [7:0] dv, input logic [2:0] dl,
                           input logic [7:0] bad, input bit restart);
        automatic int t = 0;
        automatic int nb;
        automatic bit bits_ok = 1;
        @(negedge clk);
        cur_rd = rd; cur_n = int'(lm1) + 1; cur_addr = ad; cur_wd = wd; tgt_bad = bad;
        exp_h = (dv == 0) ? 1 : int'(dv); exp_d = int'(dl);
        mon_clear();
        rd_nwr = rd; len_m1 = lm1; reg_addr = ad; wdata = wd; clk_div = dv; sda_dly = dl;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9 busy after start", {63'd0, busy}, 64'd1);
        if (restart) begin
            repeat (20) @(negedge clk);
            reg_addr = ~ad; wdata = ~wd; rd_nwr = ~rd; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (ndone == 0 && t < 60000) begin @(negedge clk); t++; end
        if (rd) begin
            chk(rdata == exp_rdata(), "R5 read data", rdata, exp_rdata());
            chk(err == (exp_eidx() != 0) && int'(err_idx) == exp_eidx(), "R6 parity error index",
                {59'd0, err, err_idx}, {59'd0, exp_eidx() != 0, 4'(exp_eidx())});
        end
        repeat (exp_d + 4) @(negedge clk);
        nb = 9 * (cur_n + 1);
        chk(nrise == nb + 1, "R2 clock edge count", 64'(nrise), 64'(nb + 1));
        for (int i = 0; i < nb && i < 100; i++) if (bits[i] !== exp_bit(i)) bits_ok = 0;
        chk(bits_ok, rd ? "R3 R5 frame bits" : "R3 R4 frame bits", {63'd0, bits_ok}, 64'd1);
        chk(nstart == 1 && nstop == 1, "R2 start/stop conditions",
            64'(nstart * 16 + nstop), 64'h11);
        chk(!per_bad, "R7 clock phase length", {63'd0, per_bad}, 64'd0);
        chk(!dly_bad, "R8 data change delay", {63'd0, dly_bad}, 64'd0);
        chk(ndone == 1 && !busy, restart ? "R10 single done" : "R9 done pulse",
            64'(ndone), 64'd1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({scl_o, sda_o, sda_oe, busy, done, err} == 6'b111000, "R1 reset/idle state",
            {58'd0, scl_o, sda_o, sda_oe, busy, done, err}, 64'b111000);

        // R12 / R13: overrides and sense
        scl_ovr_en = 1; scl_ovr_val = 0;
        @(negedge clk);
        chk(scl_o == 0 && sda_o == 1 && sda_oe == 1, "R12 clock override",
            {61'd0, scl_o, sda_o, sda_oe}, 64'b011);
        sda_ovr_en = 1; sda_ovr_val = 0;
        @(negedge clk);
        chk(sda_o == 0 && sda_oe == 1 && scl_o == 0, "R12 data override",
            {61'd0, scl_o, sda_o, sda_oe}, 64'b001);
        repeat (2) @(negedge clk);
        chk(scl_state == 0 && sda_state == 0, "R13 sense low", {62'd0, scl_state, sda_state}, 64'd0);
        scl_ovr_en = 0; sda_ovr_en = 0;
        @(negedge clk);
        chk(scl_state == 0 && sda_state == 0, "R13 sense lag", {62'd0, scl_state, sda_state}, 64'd0);
        repeat (2) @(negedge clk);
        chk(scl_state == 1 && sda_state == 1, "R13 sense high", {62'd0, scl_state, sda_state}, 64'd3);

        // directed corners
        run_txn(0, 3'd7, 8'hA5, 64'h0123_4567_89AB_CDEF, 8'd0, 3'd0, 8'h00, 0);   // R7 div 0
        run_txn(1, 3'd0, 8'h3C, 64'h0000_0000_0000_00E7, 8'd255, 3'd7, 8'h00, 0); // R8 max
        run_txn(1, 3'd4, 8'h11, 64'h0000_0055_AA0F_F000, 8'd3, 3'd1, 8'h0A, 0);   // R6 first bad=2
        run_txn(1, 3'd7, 8'hFE, 64'hDEAD_BEEF_CAFE_F00D, 8'd2, 3'd1, 8'h80, 0);   // R6 last byte
        run_txn(0, 3'd2, 8'h42, 64'h0000_0000_0077_8899, 8'd4, 3'd2, 8'h00, 1);   // R10 restart

        // R11 abort mid-frame
        @(negedge clk);
        mon_clear();
        rd_nwr = 0; len_m1 = 3'd3; reg_addr = 8'h00; wdata = '0; clk_div = 8'd4; sda_dly = 3'd2;
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (37) @(negedge clk);
        abort = 1;
        @(negedge clk);
        abort = 0;
        chk({busy, scl_o, sda_o, sda_oe} == 4'b0111, "R11 abort to idle",
            {60'd0, busy, scl_o, sda_o, sda_oe}, 64'b0111);
        repeat (100) @(negedge clk);
        chk(ndone == 0, "R11 no done on abort", 64'(ndone), 64'd0);

        // constrained random
        for (int n = 0; n < 24; n++) begin
            automatic logic [7:0] dv = 8'($urandom_range(0, 6));
            automatic int h = (dv == 0) ? 1 : int'(dv);
            automatic logic [2:0] dl = 3'($urandom_range(0, h - 1));
            automatic logic rd = 1'($urandom_range(0, 1));
            automatic logic [7:0] bad = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            run_txn(rd, 3'($urandom), 8'($urandom), {$urandom, $urandom}, dv, dl, bad, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule